// File: doc/BRIEF.md
# Register-Conditioned Branch Unit

This block resolves branches for a load-store RISC core whose words and instructions are 32 bits wide. For each decoded branch it receives the value of a target register and the value of a condition register. It also receives a count field, whose three low bits choose the test, and a link request with a destination register index. In the same cycle it reports whether the branch is taken and what the next program counter is. A branch can only reach an address that an earlier instruction placed in a register. There is no relative or direct target.

The unit holds the program counter. That register has two transitions. HOLD keeps its value when the advance enable is low. ADVANCE loads the computed next address when the enable is high. The address written by a linking branch is the address of the instruction that follows the branch, which is PC+4. The link write takes place whether or not the condition passes, so the "never" test paired with a link request simply saves the return address.

Top module: `branch_unit`

## Requirements
- R1: While reset is asserted, and immediately after it, the program counter reads zero.
- R2: Condition code 000 is never taken. The reserved codes 110 and 111 are never taken either. In each of these cases the next PC is PC+4.
- R3: Condition code 001 is always taken. When a branch is taken, the next PC equals the full 32-bit target register value.
- R4: Code 010 is taken when the condition register is zero. Code 011 is taken when the condition register is nonzero.
- R5: Code 100 is taken when the condition register, read as a signed value, is zero or positive. Code 101 is taken when it is negative, which means bit 31 is set.
- R6: Only bits [2:0] of the count field select the test. Its upper bits change no output.
- R7: A valid branch with the link request set asserts the link write enable whatever the condition outcome. It presents the requested register index, and the link data is PC+4. Without a link request the link write enable stays low.
- R8: On a clock edge with the advance enable high, the PC loads the next PC. With the enable low, the PC holds its value.
- R9: When the branch-valid input is low, nothing is taken, the link write enable is low, and the next PC is PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | Load next PC into the PC on this edge |
| br_valid | input | 1 | Current instruction is a branch |
| cnt_field | input | 12 | Count field of the branch; bits [2:0] are the condition code |
| tgt_val | input | 32 | Value of the target register |
| cond_val | input | 32 | Value of the condition register |
| link_req | input | 1 | Branch is the linking form |
| link_idx_in | input | 5 | Register index to receive the return address |
| taken | output | 1 | Branch is taken |
| next_pc | output | 32 | Address of the next instruction |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Register file write enable for the link |
| link_idx | output | 5 | Register index of the link write |
| link_data | output | 32 | Return address (PC+4) |

## Verification
The bench sweeps all eight condition codes against boundary values of the condition register: zero, one, all ones, the largest positive value and the most negative value. It does this with the upper count bits both clear and set, and with the link request on and off. A design that tested the sign with an unsigned comparison would misjudge 0x8000_0000 under codes 100 and 101. A design that decoded more count bits would change its answer when the upper bits are set. A design that gated the link with the condition would drop the return address under code 000. Advancing with not-taken branches and with non-branch instructions exposes an off-by-one increment or a PC that moves while the enable is low.

// File: rtl/bru_pkg.sv
package bru_pkg;
    localparam int COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        COND_NEVER   = 3'b000,
        COND_ALWAYS  = 3'b001,
        COND_ZERO    = 3'b010,
        COND_NONZERO = 3'b011,
        COND_NONNEG  = 3'b100,
        COND_NEG     = 3'b101,
        COND_RSV6    = 3'b110,
        COND_RSV7    = 3'b111
    } cond_e;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e            code,
    input  logic [XLEN-1:0]  val,
    output logic             met
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (val == '0);
    assign is_neg  = val[XLEN-1];

    always_comb begin
        unique case (code)
            COND_NEVER:   met = 1'b0;
            COND_ALWAYS:  met = 1'b1;
            COND_ZERO:    met = is_zero;
            COND_NONZERO: met = !is_zero;
            COND_NONNEG:  met = !is_neg;
            COND_NEG:     met = is_neg;
            COND_RSV6:    met = 1'b0;
            COND_RSV7:    met = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_seq_pc.sv
module bru_seq_pc #(
    parameter int XLEN       = 32,
    parameter int INSTR_BITS = 32
) (
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] seq_pc
);
    localparam int STEP = INSTR_BITS / 8;

    assign seq_pc = pc + XLEN'(STEP);
endmodule

// File: rtl/bru_link_gen.sv
module bru_link_gen #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic             br_valid,
    input  logic             link_req,
    input  logic [IDX_W-1:0] idx_in,
    input  logic [XLEN-1:0]  ret_addr,
    output logic             we,
    output logic [IDX_W-1:0] idx,
    output logic [XLEN-1:0]  data
);
    assign we   = br_valid && link_req;
    assign idx  = idx_in;
    assign data = ret_addr;
endmodule

// File: rtl/branch_unit.sv
module branch_unit
    import bru_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NREGS      = 32,
    parameter int CNT_W      = 12,
    parameter int INSTR_BITS = 32,
    localparam int IDX_W     = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             br_valid,
    input  logic [CNT_W-1:0] cnt_field,
    input  logic [XLEN-1:0]  tgt_val,
    input  logic [XLEN-1:0]  cond_val,
    input  logic             link_req,
    input  logic [IDX_W-1:0] link_idx_in,
    output logic             taken,
    output logic [XLEN-1:0]  next_pc,
    output logic [XLEN-1:0]  pc,
    output logic             link_we,
    output logic [IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]  link_data
);
    cond_e           code;
    logic            cond_met;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] pc_q;
    logic            unused_cnt_hi;

    assign code          = cond_e'(cnt_field[COND_W-1:0]);
    assign unused_cnt_hi = ^cnt_field[CNT_W-1:COND_W];

    bru_cond_eval #(.XLEN(XLEN)) u_cond (
        .code (code),
        .val  (cond_val),
        .met  (cond_met)
    );

    bru_seq_pc #(.XLEN(XLEN), .INSTR_BITS(INSTR_BITS)) u_seq (
        .pc     (pc_q),
        .seq_pc (seq_pc)
    );

    bru_link_gen #(.XLEN(XLEN), .IDX_W(IDX_W)) u_link (
        .br_valid (br_valid),
        .link_req (link_req),
        .idx_in   (link_idx_in),
        .ret_addr (seq_pc),
        .we       (link_we),
        .idx      (link_idx),
        .data     (link_data)
    );

    assign taken   = br_valid && cond_met;
    assign next_pc = taken ? tgt_val : seq_pc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else if (advance)
            pc_q <= next_pc;
    end

    assign pc = pc_q;
endmodule

// File: rtl/branch_unit_check.sv
module branch_unit_check #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             advance,
    input logic             br_valid,
    input logic [CNT_W-1:0] cnt_field,
    input logic [XLEN-1:0]  tgt_val,
    input logic [XLEN-1:0]  cond_val,
    input logic             link_req,
    input logic             taken,
    input logic [XLEN-1:0]  next_pc,
    input logic [XLEN-1:0]  pc,
    input logic             link_we,
    input logic [XLEN-1:0]  link_data
);
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(pc)); // R8
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> pc == $past(next_pc)); // R8
    AST_NEVER_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_field[2:0] == 3'd0 || cnt_field[2:0] == 3'd6 || cnt_field[2:0] == 3'd7)
        |-> !taken && next_pc == pc + 32'd4); // R2
    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && cnt_field[2:0] == 3'd1) |-> taken); // R3
    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> next_pc == tgt_val); // R3
    AST_ZERO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && cnt_field[2:0] == 3'd2) |-> taken == (cond_val == '0)); // R4
    AST_NEG_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && cnt_field[2:0] == 3'd5) |-> taken == cond_val[XLEN-1]); // R5
    AST_LINK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && link_req) |-> link_we && link_data == pc + 32'd4); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> !taken && !link_we); // R9
endmodule

bind branch_unit branch_unit_check #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .br_valid  (br_valid),
    .cnt_field (cnt_field),
    .tgt_val   (tgt_val),
    .cond_val  (cond_val),
    .link_req  (link_req),
    .taken     (taken),
    .next_pc   (next_pc),
    .pc        (pc),
    .link_we   (link_we),
    .link_data (link_data)
);

// File: tb/branch_unit_test.sv
module branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance = 1'b0;
    logic        br_valid = 1'b0;
    logic [11:0] cnt_field = '0;
    logic [31:0] tgt_val = '0;
    logic [31:0] cond_val = '0;
    logic        link_req = 1'b0;
    logic [4:0]  link_idx_in = '0;
    logic        taken;
    logic [31:0] next_pc;
    logic [31:0] pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    branch_unit uut (
        .clk(clk), .rst_n(rst_n), .advance(advance), .br_valid(br_valid),
        .cnt_field(cnt_field), .tgt_val(tgt_val), .cond_val(cond_val),
        .link_req(link_req), .link_idx_in(link_idx_in), .taken(taken),
        .next_pc(next_pc), .pc(pc), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data)
    );

    task automatic chk(input string req, input [31:0] act, input [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_taken(input [2:0] code, input [31:0] v);
        case (code)
            3'd1: return 1'b1;
            3'd2: return v == 32'd0;
            3'd3: return v != 32'd0;
            3'd4: return !v[31];
            3'd5: return v[31];
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] conds [6];
        logic [31:0] base;
        conds[0] = 32'h0000_0000; conds[1] = 32'h0000_0001;
        conds[2] = 32'hFFFF_FFFF; conds[3] = 32'h7FFF_FFFF;
        conds[4] = 32'h8000_0000; conds[5] = 32'h0000_0100;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc in reset", pc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc after reset", pc, 32'd0);
        chk("R9 idle next_pc", next_pc, 32'd4);

        // load PC via always-taken branch
        br_valid = 1'b1; cnt_field = 12'h001; tgt_val = 32'h0000_1000; advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        chk("R8 advance loads target", pc, 32'h0000_1000);
        base = pc;

        // exhaustive code sweep with advance low
        for (int hi = 0; hi < 2; hi++) begin
            for (int code = 0; code < 8; code++) begin
                for (int c = 0; c < 6; c++) begin
                    for (int lk = 0; lk < 2; lk++) begin
                        bit et;
                        cnt_field = {(hi != 0) ? 9'h1A5 : 9'h000, 3'(code)};
                        cond_val = conds[c];
                        tgt_val = 32'h0000_8000 + 32'(code * 16 + c);
                        link_req = lk[0];
                        link_idx_in = 5'(code * 3 + c);
                        br_valid = 1'b1;
                        #2;
                        et = exp_taken(3'(code), conds[c]);
                        chk((code < 2 || code > 5) ? "R2 R3 R6 taken" :
                            (code < 4) ? "R4 R6 taken" : "R5 R6 taken",
                            {31'd0, taken}, {31'd0, et});
                        chk("R2 R3 next_pc", next_pc, et ? tgt_val : base + 32'd4);
                        chk("R7 link_we", {31'd0, link_we}, {31'd0, lk[0]});
                        if (lk != 0) begin
                            chk("R7 link_idx", {27'd0, link_idx}, {27'd0, 5'(code * 3 + c)});
                            chk("R7 link_data", link_data, base + 32'd4);
                        end
                        @(negedge clk);
                        chk("R8 hold without advance", pc, base);
                    end
                end
            end
        end

        // non-branch with link request: no link, no take
        br_valid = 1'b0; link_req = 1'b1; cnt_field = 12'h001;
        #2;
        chk("R9 no take when not branch", {31'd0, taken}, 32'd0);
        chk("R9 no link when not branch", {31'd0, link_we}, 32'd0);
        chk("R9 next_pc sequential", next_pc, base + 32'd4);
        advance = 1'b1;
        @(negedge clk);
        chk("R8 R9 advance sequential", pc, base + 32'd4);
        // not-taken branch advancing
        br_valid = 1'b1; link_req = 1'b0; cnt_field = 12'h002; cond_val = 32'd7;
        @(negedge clk);
        chk("R8 R4 not-taken advance", pc, base + 32'd8);
        // taken negative branch advancing
        cnt_field = 12'hFF5; cond_val = 32'h8000_0000; tgt_val = 32'h0000_2468;
        @(negedge clk);
        chk("R8 R5 taken advance", pc, 32'h0000_2468);
        advance = 1'b0; br_valid = 1'b0;
        @(negedge clk);
        chk("R8 hold", pc, 32'h0000_2468);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule